// File: doc/BRIEF.md
# Configurable Pseudo-Random Shift Generator

This block produces a stream of pseudo-random bits and words from a linear feedback shift register that moves toward its most significant end. The register width is a parameter restricted to 3, 8 or 32 bits. Each width has its own fixed set of feedback taps, chosen so that the register runs through every nonzero value before it repeats. On each enabled cycle the word shifts left by one place, the top bit is dropped, and the XOR of the tapped bits enters at the bottom.

A seed only picks where in the fixed cycle the sequence starts. Loading an all-zero seed would lock the register at zero for ever, so such a seed is refused. The block starts from the all-ones word instead and raises an error flag for one cycle. Consumers can take the whole word as a number, or take the single new bit as a serial random bit.

Top module: `lfsr_word_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `word_o` becomes all ones, `fresh_bit_o` becomes 0 and `seed_err_o` becomes 0.
- R2: On a cycle with `step_i` high and `load_i` low, the next `word_o` equals the old word shifted left by one, with the old top bit dropped and the feedback bit in bit 0.
- R3: The taps are numbered 1..N with tap 1 as the LSB (word bit 0). The feedback bit is the XOR of taps 3,2 for N=3, of taps 8,6,5,4 for N=8, and of taps 32,22,2,1 for N=32. Example for N=8: seed 10101000 steps to 01010001, then 10100011, then 01000110. Example for N=3: 111 steps to 110, 100, 001, 010, 101, 011 and then back to 111.
- R4: For N=3 and N=8, stepping from any nonzero word returns to that word after exactly 2^N-1 steps and not earlier, and `word_o` is never zero.
- R5: When `load_i` is high with a nonzero `seed_i`, the next `word_o` equals `seed_i` and the next `fresh_bit_o` is 0.
- R6: When `load_i` is high with `seed_i` all zero, the next `word_o` is all ones and `seed_err_o` is 1 for exactly that one following cycle. Otherwise `seed_err_o` is 0.
- R7: When `load_i` and `step_i` are both high, the load takes effect and no shift happens.
- R8: `fresh_bit_o` is registered in the same edge as the word and equals the bit shifted into bit 0 by the last step, so after a step `fresh_bit_o` equals `word_o[0]`.
- R9: With `load_i` and `step_i` both low, `word_o` and `fresh_bit_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load `seed_i` as the new start word |
| seed_i | input | WIDTH | Seed word; zero is refused |
| step_i | input | 1 | Advance the register by one position |
| word_o | output | WIDTH | Current register word |
| fresh_bit_o | output | 1 | Bit shifted in by the most recent step |
| seed_err_o | output | 1 | One-cycle flag after a zero seed was refused |

## Verification
A load and a step can be requested in the same cycle. The zero-seed check and the shift can also meet there, when a zero seed arrives together with `step_i`. The bench raises both strobes on one edge, once with a nonzero seed and once with a zero seed. A correct design leaves the seed itself, or the all-ones word, in the register. A shifted value would show that the step won. In the zero case the error flag must be high for one cycle only, and `fresh_bit_o` must read 0 rather than a feedback bit.

// File: rtl/lfsr_pkg.sv
// Package: shared constants for the shift generator.
// Assumes the widths in use are the three listed in width_supported().
package lfsr_pkg;

    // Reports whether a width has a tap set defined.
    function automatic bit width_supported(input int w);
        return (w == 3) || (w == 8) || (w == 32);
    endfunction

    // Returns the tap mask for a width. Bit k of the mask is tap k+1.
    function automatic logic [31:0] tap_mask(input int w);
        logic [31:0] m;
        m = '0;
        case (w)
            3:  begin m[2] = 1'b1; m[1] = 1'b1; end
            8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
            32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsr_feedback.sv
// Module: lfsr_feedback
// Forms the feedback bit as the XOR of the tapped bits of the current word.
// Assumes WIDTH is one of the supported widths; any other width stops elaboration.
module lfsr_feedback
    import lfsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] state_i,
    output logic             fb_o
);
    localparam logic [31:0]      FULL_MASK = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] MASK      = FULL_MASK[WIDTH-1:0];

    logic [WIDTH-1:0] tapped;

    generate
        if (!width_supported(WIDTH)) begin : g_bad_width
            $error("lfsr_feedback: unsupported WIDTH");
        end
        // Keep only the tapped positions; untapped ones are tied to zero.
        for (genvar k = 0; k < WIDTH; k++) begin : g_tap
            if (MASK[k]) begin : g_on
                assign tapped[k] = state_i[k];
            end else begin : g_off
                assign tapped[k] = 1'b0;
            end
        end
    endgenerate

    // Reduce the tapped bits to a single parity bit.
    always_comb fb_o = ^tapped;

endmodule

// File: rtl/lfsr_seed_guard.sv
// Module: lfsr_seed_guard
// Checks a proposed seed. A nonzero seed passes through unchanged. An all-zero
// seed is replaced by all ones and flagged.
// Assumes it is purely combinational and is sampled by the register owner.
module lfsr_seed_guard #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] start_o,
    output logic             zero_o
);
    localparam logic [WIDTH-1:0] SAFE_WORD = '1;

    // Detect the lock-up seed and pick the start word.
    always_comb begin
        zero_o  = (seed_i == '0);
        start_o = zero_o ? SAFE_WORD : seed_i;
    end

endmodule

// File: rtl/lfsr_word_gen.sv
// Module: lfsr_word_gen
// Left-shifting pseudo-random generator. The feedback enters at bit 0. There
// is a seed load with zero-seed refusal, and a step enable.
// Assumes a synchronous active-low reset, and that load outranks step.
module lfsr_word_gen #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] word_o,
    output logic             fresh_bit_o,
    output logic             seed_err_o
);
    localparam logic [WIDTH-1:0] SAFE_WORD = '1;

    logic [WIDTH-1:0] word_q;
    logic             bit_q;
    logic             err_q;
    logic             fb;
    logic [WIDTH-1:0] start_word;
    logic             start_zero;

    lfsr_feedback #(.WIDTH(WIDTH)) u_feedback (
        .state_i (word_q),
        .fb_o    (fb)
    );

    lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
        .seed_i  (seed_i),
        .start_o (start_word),
        .zero_o  (start_zero)
    );

    // Update the register word, the fresh bit and the seed error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= SAFE_WORD;
            bit_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= load_i && start_zero;
            if (load_i) begin
                word_q <= start_word;
                bit_q  <= 1'b0;
            end else if (step_i) begin
                word_q <= {word_q[WIDTH-2:0], fb};
                bit_q  <= fb;
            end
        end
    end

    assign word_o      = word_q;
    assign fresh_bit_o = bit_q;
    assign seed_err_o  = err_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (word_o == SAFE_WORD && !fresh_bit_o && !seed_err_o));

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (word_o[WIDTH-1:1] == $past(word_o[WIDTH-2:0])));

    // R4
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_o != '0);

    // R5 R7
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (word_o == $past(seed_i) && !fresh_bit_o));

    // R6
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (word_o == SAFE_WORD && seed_err_o));

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && seed_i == '0) |=> !seed_err_o);

    // R8
    fresh_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (fresh_bit_o == word_o[0]));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(word_o) && $stable(fresh_bit_o)));

endmodule

// File: tb/tb_lfsr_word_gen.sv
module tb_lfsr_word_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // 8-bit instance
    logic       ld8 = 0, st8 = 0;
    logic [7:0] sd8 = '0;
    logic [7:0] w8;
    logic       b8, e8;
    lfsr_word_gen #(.WIDTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .load_i(ld8), .seed_i(sd8), .step_i(st8),
        .word_o(w8), .fresh_bit_o(b8), .seed_err_o(e8));

    // 3-bit instance
    logic       ld3 = 0, st3 = 0;
    logic [2:0] sd3 = '0;
    logic [2:0] w3;
    logic       b3, e3;
    lfsr_word_gen #(.WIDTH(3)) dut_w3 (
        .clk(clk), .rst_n(rst_n), .load_i(ld3), .seed_i(sd3), .step_i(st3),
        .word_o(w3), .fresh_bit_o(b3), .seed_err_o(e3));

    // 32-bit instance
    logic        ld32 = 0, st32 = 0;
    logic [31:0] sd32 = '0;
    logic [31:0] w32;
    logic        b32, e32;
    lfsr_word_gen #(.WIDTH(32)) dut_w32 (
        .clk(clk), .rst_n(rst_n), .load_i(ld32), .seed_i(sd32), .step_i(st32),
        .word_o(w32), .fresh_bit_o(b32), .seed_err_o(e32));

    // Reference steps written from the tap lists in the requirements.
    function automatic logic [7:0] nx8(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction
    function automatic logic [2:0] nx3(input logic [2:0] x);
        return {x[1:0], x[2] ^ x[1]};
    endfunction
    function automatic logic [31:0] nx32(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs were driven at the falling edge; sample after the rise.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        check("R1 word8", w8, 8'hFF);
        check("R1 bit8", b8, 0);
        check("R1 err8", e8, 0);
        check("R1 word3", w3, 3'b111);
        check("R1 word32", w32, 32'hFFFF_FFFF);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load8(input logic [7:0] s);
        @(negedge clk);
        ld8 = 1; sd8 = s; st8 = 0;
        tick();
        @(negedge clk);
        ld8 = 0;
    endtask

    task automatic t_example8();
        load8(8'b1010_1000);
        check("R5 load", w8, 8'b1010_1000);
        check("R5 bit cleared", b8, 0);
        @(negedge clk); st8 = 1; tick();
        check("R3 ex step1", w8, 8'b0101_0001);
        check("R8 fresh bit", b8, 1);
        @(negedge clk); tick();
        check("R3 ex step2", w8, 8'b1010_0011);
        @(negedge clk); tick();
        check("R3 ex step3", w8, 8'b0100_0110);
        check("R8 fresh bit 0", b8, 0);
        @(negedge clk); st8 = 0;
    endtask

    task automatic t_example3();
        logic [2:0] seq [7] = '{3'b110, 3'b100, 3'b001, 3'b010, 3'b101, 3'b011, 3'b111};
        @(negedge clk); ld3 = 1; sd3 = 3'b111; tick();
        @(negedge clk); ld3 = 0; st3 = 1;
        for (int i = 0; i < 7; i++) begin
            tick();
            check("R3 n3 sequence", w3, seq[i]);
            @(negedge clk);
        end
        st3 = 0;
    endtask

    task automatic t_period8();
        logic [7:0] start, model;
        start = 8'h5A;
        load8(start);
        model = start;
        @(negedge clk); st8 = 1;
        for (int i = 1; i <= 255; i++) begin
            tick();
            model = nx8(model);
            check("R2 n8 model", w8, model);
            if (w8 == 8'h00) check("R4 n8 zero seen", w8, 8'h01);
            if (i < 255 && w8 == start) check("R4 n8 early repeat", i, 255);
            @(negedge clk);
        end
        st8 = 0;
        check("R4 n8 period", w8, start);
    endtask

    task automatic t_period3();
        logic [2:0] model;
        @(negedge clk); ld3 = 1; sd3 = 3'b010; tick();
        @(negedge clk); ld3 = 0; st3 = 1;
        model = 3'b010;
        for (int i = 1; i <= 7; i++) begin
            tick();
            model = nx3(model);
            check("R4 n3 model", w3, model);
            if (w3 == 3'b000) check("R4 n3 zero seen", w3, 3'b001);
            if (i < 7 && w3 == 3'b010) check("R4 n3 early repeat", i, 7);
            @(negedge clk);
        end
        st3 = 0;
        check("R4 n3 period", w3, 3'b010);
    endtask

    task automatic t_w32();
        logic [31:0] model;
        @(negedge clk); ld32 = 1; sd32 = 32'h8020_0003; tick();
        @(negedge clk); ld32 = 0; st32 = 1;
        model = 32'h8020_0003;
        for (int i = 0; i < 40; i++) begin
            tick();
            model = nx32(model);
            check("R3 n32 taps", w32, model);
            check("R8 n32 fresh bit", b32, model[0]);
            @(negedge clk);
        end
        st32 = 0;
    endtask

    task automatic t_zero_seed();
        load8(8'h3C);
        @(negedge clk); ld8 = 1; sd8 = 8'h00; st8 = 1; tick();
        check("R6 zero seed word", w8, 8'hFF);
        check("R6 err set", e8, 1);
        check("R7 zero seed no shift bit", b8, 0);
        @(negedge clk); ld8 = 0; st8 = 0; tick();
        check("R6 err one cycle", e8, 0);
        check("R9 idle hold", w8, 8'hFF);
    endtask

    task automatic t_priority();
        load8(8'h81);
        @(negedge clk); st8 = 1; tick();
        check("R2 step before priority", w8, nx8(8'h81));
        @(negedge clk); ld8 = 1; sd8 = 8'h47; tick();
        check("R7 load wins", w8, 8'h47);
        check("R7 bit cleared", b8, 0);
        check("R6 no err on nonzero", e8, 0);
        @(negedge clk); ld8 = 0; tick();
        check("R2 step after load", w8, nx8(8'h47));
        @(negedge clk); st8 = 0;
    endtask

    task automatic t_idle();
        logic [7:0] hold;
        logic       hb;
        @(negedge clk); st8 = 1; tick();
        @(negedge clk); st8 = 0;
        hold = w8; hb = b8;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R9 word held", w8, hold);
            check("R9 bit held", b8, hb);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_example8();
        t_example3();
        t_period8();
        t_period3();
        t_w32();
        t_zero_seed();
        t_priority();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule